// File: doc/BRIEF.md
# Low-Power Compare Timer with Waveform Output

This block is a 16-bit up-counting timer for housekeeping in a low-power domain. It counts from zero up to a programmable period, wraps, and drives a waveform pin whose level comes from comparing the counter against a programmable compare value. Software controls it through a small single-cycle register port. It can start in a free-running mode or a run-once mode, and the run-once request can also be issued while the timer is already free-running. A start can be held back until a chosen edge appears on an external trigger pin.

Compare and period values are written into holding registers. In deferred mode they reach the counting logic only when the current period ends. In direct mode they are used on the following cycle. A power-of-two prescaler slows the count rate. A compare hit and a period hit each set a sticky flag. Each flag can be cleared by writing a one to it in a clear register, and the flags are masked by an enable register onto a single interrupt line.

Register map (word addresses): 0 control (bit0 enable, bit1 run-once start, bit2 free-run start; the start bits are write-only pulses, reading returns only the enable bit), 1 configuration (bits 2:0 prescale exponent, bit3 deferred update, bit4 polarity high, bits 6:5 trigger select: 00 software, 01 rising, 10 falling, 11 both edges), 2 counter (read only), 3 compare, 4 period, 5 interrupt enable, 6 flags (read only), 7 flag clear (write only, reads zero). In registers 5, 6 and 7, bit0 is the compare event and bit1 is the period event.

Top module: `lpct_timer`

## Requirements
- R1: While running, the counter advances by one per count tick. A tick at the period value returns it to 0.
- R2: A tick with the counter equal to the active compare value sets flag bit0 on the same edge. A tick with the counter equal to the active period value sets flag bit1.
- R3: Flags are sticky. Writing a one to a bit of register 7 clears that flag. Flags with a zero written to them keep their value.
- R4: irq_o is high exactly when some flag is set whose enable bit in register 5 is also set.
- R5: With polarity high, wave_o is high while the counter is above the active compare value. With polarity low, wave_o is the inverse of that.
- R6: A run-once start counts from 0. The first compare or period hit clears the counter to 0 and stops the timer.
- R7: A run-once start written while the timer is free-running stops it at its next compare or period hit.
- R8: With a nonzero trigger select, a start leaves the counter at 0 until the selected edge is seen on trig_i. Counting starts on the third clock edge after trig_i changes. An edge that was not selected has no effect.
- R9: With deferred update on, a new compare or period value takes effect only when the current period ends.
- R10: With deferred update off, a new period value is used from the second clock edge after the write.
- R11: With prescale exponent E, a running timer ticks once every 2^E clock cycles, with the first tick 2^E cycles after the start edge.
- R12: Clearing the enable bit resets the counter to 0, stops the timer and drops a pending triggered start. Start bits written while the timer is disabled are ignored.
- R13: After reset every register reads 0 except the period, which reads 0xFFFF. wave_o is 1 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| trig_i | input | 1 | Asynchronous external start trigger |
| wave_o | output | 1 | Compare waveform output |
| irq_o | output | 1 | Masked interrupt line |

## Verification
Two states are the hardest to reach from the ports. The first is a run-once request that arrives partway through a free-running period and after the compare point, so the timer has to stop on the period hit and not on the compare hit. The stimulus reaches it by counting cycles from the start write and placing the run-once write when the counter is past the compare value. The second is a triggered start that is pending when the enable bit falls. The stimulus arms the timer, toggles enable off and on, and then supplies the selected edge, which must now be ignored. Deferred and direct updates are told apart by writing a smaller period mid-period and reading the counter at a cycle where the two behaviours give different values.

// File: rtl/lpct_pkg.sv
package lpct_pkg;

    localparam int ADDR_W = 3;
    localparam int N_EVT  = 2;
    localparam int CFG_W  = 7;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PER  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd6;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd7;

    localparam int CTL_EN     = 0;
    localparam int CTL_SINGLE = 1;
    localparam int CTL_CONT   = 2;

    localparam int EVT_CMP = 0;
    localparam int EVT_PER = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_st_e;

    typedef enum logic [1:0] {
        TRG_SOFT = 2'd0,
        TRG_RISE = 2'd1,
        TRG_FALL = 2'd2,
        TRG_BOTH = 2'd3
    } trig_mode_e;

    typedef struct packed {
        trig_mode_e trig;
        logic       pol_high;
        logic       preload;
        logic [2:0] psc;
    } cfg_t;

endpackage

// File: rtl/lpct_prescaler.sv
module lpct_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] exp_sel,
    output logic             tick
);
    localparam int PS_W = (1 << PSC_W) - 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    always_comb begin
        mask = ~({PS_W{1'b1}} << exp_sel);
        tick = run && ((ps_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_q + 1'b1;
        end
    end
endmodule

// File: rtl/lpct_trig_sync.sv
module lpct_trig_sync import lpct_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_i,
    input  trig_mode_e mode,
    output logic       edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   synced;
    logic                   rise;
    logic                   fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q[0] <= trig_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    always_comb begin
        synced = sync_q[SYNC_STAGES-1];
        rise   = synced && !prev_q;
        fall   = !synced && prev_q;
        unique case (mode)
            TRG_RISE: edge_o = rise;
            TRG_FALL: edge_o = fall;
            TRG_BOTH: edge_o = rise || fall;
            default:  edge_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpct_core.sv
module lpct_core import lpct_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start_single,
    input  logic             start_cont,
    input  logic             trig_edge,
    input  logic             soft_trig,
    input  logic             tick,
    input  logic             preload,
    input  logic             pol_high,
    input  logic [CNT_W-1:0] cmp_sh,
    input  logic [CNT_W-1:0] per_sh,
    output logic [CNT_W-1:0] cnt_q,
    output run_st_e          st_q,
    output logic             single_q,
    output logic             hit_cmp,
    output logic             hit_per,
    output logic             wave
);
    logic [CNT_W-1:0] act_cmp;
    logic [CNT_W-1:0] act_per;
    logic             above;

    always_comb begin
        hit_cmp = tick && (cnt_q == act_cmp);
        hit_per = tick && (cnt_q == act_per);
        above   = cnt_q > act_cmp;
        wave    = pol_high ? above : !above;
    end

    // active compare/period: direct, idle, or end of period
    always_ff @(posedge clk) begin
        if (rst) begin
            act_cmp <= '0;
            act_per <= '1;
        end else if (!preload || st_q != ST_RUN || hit_per) begin
            act_cmp <= cmp_sh;
            act_per <= per_sh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q    <= '0;
            st_q     <= ST_IDLE;
            single_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_single || start_cont) begin
                        single_q <= start_single;
                        cnt_q    <= '0;
                        st_q     <= soft_trig ? ST_RUN : ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (start_single) single_q <= 1'b1;
                    if (trig_edge)    st_q     <= ST_RUN;
                end
                ST_RUN: begin
                    if (start_single) single_q <= 1'b1;
                    if (single_q && (hit_cmp || hit_per)) begin
                        cnt_q    <= '0;
                        st_q     <= ST_IDLE;
                        single_q <= 1'b0;
                    end else if (hit_per) begin
                        cnt_q <= '0;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lpct_regs.sv
module lpct_regs import lpct_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [N_EVT-1:0]  evt,
    output logic [CNT_W-1:0]  rdata,
    output logic              en_q,
    output cfg_t              cfg_q,
    output logic [CNT_W-1:0]  cmp_sh,
    output logic [CNT_W-1:0]  per_sh,
    output logic [N_EVT-1:0]  ien_q,
    output logic [N_EVT-1:0]  stat_q,
    output logic [N_EVT-1:0]  clr_mask,
    output logic              start_single,
    output logic              start_cont,
    output logic              irq
);
    logic wr_ctrl;

    always_comb begin
        wr_ctrl      = we && (addr == A_CTRL);
        start_single = wr_ctrl && wdata[CTL_SINGLE];
        start_cont   = wr_ctrl && wdata[CTL_CONT];
        clr_mask     = (we && (addr == A_CLR)) ? wdata[N_EVT-1:0] : '0;
        irq          = |(stat_q & ien_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            cfg_q  <= '0;
            cmp_sh <= '0;
            per_sh <= '1;
            ien_q  <= '0;
        end else if (we) begin
            unique case (addr)
                A_CTRL:  en_q   <= wdata[CTL_EN];
                A_CFG:   cfg_q  <= cfg_t'(wdata[CFG_W-1:0]);
                A_CMP:   cmp_sh <= wdata;
                A_PER:   per_sh <= wdata;
                A_IEN:   ien_q  <= wdata[N_EVT-1:0];
                default: ;
            endcase
        end
    end

    // sticky flags: a set beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            for (int i = 0; i < N_EVT; i++) begin
                if (evt[i])           stat_q[i] <= 1'b1;
                else if (clr_mask[i]) stat_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: rdata[CTL_EN]      = en_q;
            A_CFG:  rdata[CFG_W-1:0]   = cfg_q;
            A_CNT:  rdata              = cnt;
            A_CMP:  rdata              = cmp_sh;
            A_PER:  rdata              = per_sh;
            A_IEN:  rdata[N_EVT-1:0]   = ien_q;
            A_STAT: rdata[N_EVT-1:0]   = stat_q;
            default: rdata             = '0;
        endcase
    end
endmodule

// File: rtl/lpct_timer.sv
module lpct_timer import lpct_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              trig_i,
    output logic              wave_o,
    output logic              irq_o
);
    logic             en_q;
    cfg_t             cfg_q;
    logic [CNT_W-1:0] cmp_sh;
    logic [CNT_W-1:0] per_sh;
    logic [N_EVT-1:0] ien_q;
    logic [N_EVT-1:0] stat_q;
    logic [N_EVT-1:0] clr_mask;
    logic [N_EVT-1:0] evt;
    logic             start_single;
    logic             start_cont;
    logic             trig_edge;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    run_st_e          st_q;
    logic             single_q;
    logic             hit_cmp;
    logic             hit_per;
    logic             running;

    always_comb begin
        running      = (st_q == ST_RUN);
        evt          = '0;
        evt[EVT_CMP] = hit_cmp;
        evt[EVT_PER] = hit_per;
    end

    lpct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cnt(cnt_q), .evt(evt), .rdata(reg_rdata), .en_q(en_q), .cfg_q(cfg_q),
        .cmp_sh(cmp_sh), .per_sh(per_sh), .ien_q(ien_q), .stat_q(stat_q),
        .clr_mask(clr_mask), .start_single(start_single), .start_cont(start_cont),
        .irq(irq_o)
    );

    lpct_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk(clk), .rst(rst), .trig_i(trig_i), .mode(cfg_q.trig), .edge_o(trig_edge)
    );

    lpct_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst(rst), .run(running), .exp_sel(cfg_q.psc), .tick(tick)
    );

    lpct_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .en(en_q), .start_single(start_single),
        .start_cont(start_cont), .trig_edge(trig_edge),
        .soft_trig(cfg_q.trig == TRG_SOFT), .tick(tick), .preload(cfg_q.preload),
        .pol_high(cfg_q.pol_high), .cmp_sh(cmp_sh), .per_sh(per_sh),
        .cnt_q(cnt_q), .st_q(st_q), .single_q(single_q), .hit_cmp(hit_cmp),
        .hit_per(hit_per), .wave(wave_o)
    );
endmodule

// File: rtl/lpct_checker.sv
module lpct_checker import lpct_pkg::*; #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en_q,
    input logic [1:0]       st,
    input logic [CNT_W-1:0] cnt,
    input logic             single_q,
    input logic             hit_cmp,
    input logic             hit_per,
    input logic [N_EVT-1:0] stat,
    input logic [N_EVT-1:0] ien,
    input logic [N_EVT-1:0] clr_mask,
    input logic             irq
);
    // R12
    disabled_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> (cnt == '0 && st == ST_IDLE));

    // R2
    cmp_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit_cmp |=> stat[EVT_CMP]);

    // R3
    sticky_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (stat[EVT_CMP] && !clr_mask[EVT_CMP]) |=> stat[EVT_CMP]);

    // R3
    sticky_per_chk: assert property (@(posedge clk) disable iff (rst)
        (stat[EVT_PER] && !clr_mask[EVT_PER]) |=> stat[EVT_PER]);

    // R4
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat & ien) == '0) |-> !irq);

    // R8
    armed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && st == ST_ARMED) |=> cnt == '0);

    // R6
    single_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && st == ST_RUN && single_q && (hit_cmp || hit_per))
        |=> (st == ST_IDLE && cnt == '0));
endmodule

bind lpct_timer lpct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .en_q(en_q), .st(st_q), .cnt(cnt_q),
    .single_q(single_q), .hit_cmp(hit_cmp), .hit_per(hit_per),
    .stat(stat_q), .ien(ien_q), .clr_mask(clr_mask), .irq(irq_o)
);

// File: tb/lpct_timer_bench.sv
`timescale 1ns/1ps
module lpct_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        trig_i = 1'b0;
    logic        wave_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    logic [15:0] v;

    always #2 clk = ~clk;

    lpct_timer u_lpct_timer (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_i(trig_i),
        .wave_o(wave_o), .irq_o(irq_o)
    );

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h exp %0h", tag, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cnt_is(input string tag, input logic [15:0] exp);
        logic [15:0] c;
        rd(3'd2, c);
        chk(tag, c, exp);
    endtask

    task automatic restart(input logic [15:0] cfg, input logic [15:0] cmp, input logic [15:0] per);
        wr(3'd0, 16'h0);
        wr(3'd1, cfg);
        wr(3'd3, cmp);
        wr(3'd4, per);
        wr(3'd5, 16'h0);
        wr(3'd7, 16'h3);
        wr(3'd0, 16'h1);
    endtask

    task automatic t_reset;
        rd(3'd0, v); chk("R13 ctrl", v, 16'h0);
        rd(3'd1, v); chk("R13 cfg", v, 16'h0);
        rd(3'd2, v); chk("R13 cnt", v, 16'h0);
        rd(3'd3, v); chk("R13 cmp", v, 16'h0);
        rd(3'd4, v); chk("R13 per", v, 16'hFFFF);
        rd(3'd6, v); chk("R13 stat", v, 16'h0);
        chk("R13 wave", {15'd0, wave_o}, 16'h1);
        chk("R13 irq", {15'd0, irq_o}, 16'h0);
    endtask

    task automatic t_count;
        restart(16'h0, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        cnt_is("R1 k0", 16'd0);
        idle(5); cnt_is("R1 k5", 16'd5);
        idle(4); cnt_is("R1 k9", 16'd9);
        idle(1); cnt_is("R1 wrap", 16'd0);
        idle(3); cnt_is("R1 k13", 16'd3);
    endtask

    task automatic t_wave;
        restart(16'h0, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        idle(2); chk("R5 low pol below", {15'd0, wave_o}, 16'h1);
        idle(3); chk("R5 low pol above", {15'd0, wave_o}, 16'h0);
        wr(3'd1, 16'h10);
        chk("R5 high pol above", {15'd0, wave_o}, 16'h1);
        idle(4); chk("R5 high pol zero", {15'd0, wave_o}, 16'h0);
    endtask

    task automatic t_flags;
        restart(16'h0, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        idle(3); rd(3'd6, v); chk("R2 before cmp", v, 16'h0);
        idle(1); rd(3'd6, v); chk("R2 cmp flag", v, 16'h1);
        chk("R4 masked", {15'd0, irq_o}, 16'h0);
        wr(3'd5, 16'h1);
        chk("R4 enabled", {15'd0, irq_o}, 16'h1);
        idle(5); rd(3'd6, v); chk("R2 per flag", v, 16'h3);
        wr(3'd7, 16'h1);
        rd(3'd6, v); chk("R3 clear one", v, 16'h2);
        chk("R4 after clear", {15'd0, irq_o}, 16'h0);
        idle(1); rd(3'd6, v); chk("R3 sticky", v, 16'h2);
        wr(3'd5, 16'h2);
        chk("R4 per enabled", {15'd0, irq_o}, 16'h1);
    endtask

    task automatic t_single;
        restart(16'h0, 16'd3, 16'd9);
        wr(3'd0, 16'h3);
        idle(3); cnt_is("R6 at cmp", 16'd3);
        idle(3); cnt_is("R6 stopped", 16'd0);
        rd(3'd6, v); chk("R6 flags", v, 16'h1);
        idle(5); cnt_is("R6 stays", 16'd0);
    endtask

    task automatic t_cont_single;
        restart(16'h0, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        idle(5);
        wr(3'd0, 16'h3);
        idle(3); cnt_is("R7 runs to per", 16'd9);
        idle(2); cnt_is("R7 stopped", 16'd0);
        idle(9); cnt_is("R7 stays", 16'd0);
        rd(3'd6, v); chk("R7 flags", v, 16'h3);
    endtask

    task automatic t_trig;
        trig_i = 1'b0;
        restart(16'h20, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        idle(10); cnt_is("R8 rise armed", 16'd0);
        trig_i = 1'b1;
        idle(5); cnt_is("R8 rise run", 16'd2);
        trig_i = 1'b0;
        restart(16'h40, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        trig_i = 1'b1;
        idle(8); cnt_is("R8 rise ignored", 16'd0);
        trig_i = 1'b0;
        idle(5); cnt_is("R8 fall run", 16'd2);
        restart(16'h60, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        trig_i = 1'b1;
        idle(5); cnt_is("R8 both run", 16'd2);
        trig_i = 1'b0;
    endtask

    task automatic t_preload;
        restart(16'h08, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        idle(2);
        wr(3'd4, 16'd5);
        idle(5); cnt_is("R9 old period", 16'd8);
        idle(2); cnt_is("R9 wrap", 16'd0);
        idle(5); cnt_is("R9 new top", 16'd5);
        idle(1); cnt_is("R9 new wrap", 16'd0);
        restart(16'h00, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        idle(2);
        wr(3'd4, 16'd5);
        idle(2); cnt_is("R10 top", 16'd5);
        idle(1); cnt_is("R10 early wrap", 16'd0);
    endtask

    task automatic t_prescale;
        restart(16'h02, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        idle(3); cnt_is("R11 before tick", 16'd0);
        idle(4); cnt_is("R11 k7", 16'd1);
        idle(1); cnt_is("R11 k8", 16'd2);
    endtask

    task automatic t_disable;
        restart(16'h0, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        idle(5);
        wr(3'd0, 16'h0);
        idle(1); cnt_is("R12 cleared", 16'd0);
        wr(3'd0, 16'h6);
        rd(3'd0, v); chk("R12 en stays off", v, 16'h0);
        wr(3'd0, 16'h1);
        idle(5); cnt_is("R12 start ignored", 16'd0);
        trig_i = 1'b0;
        restart(16'h20, 16'd3, 16'd9);
        wr(3'd0, 16'h5);
        idle(2);
        wr(3'd0, 16'h0);
        wr(3'd0, 16'h1);
        trig_i = 1'b1;
        idle(8); cnt_is("R12 pending dropped", 16'd0);
        trig_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_wave();
        t_flags();
        t_single();
        t_cont_single();
        t_trig();
        t_preload();
        t_prescale();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule